// File: doc/BRIEF.md
# DDR3 Dynamic Termination Controller

This block runs on the device side of one DDR3 rank and decides, every clock, which on-die termination value the rank presents: none, the nominal value, or the write value. It follows the registered termination-enable pin and the decoded WRITE commands. Both are delayed by latencies that the block derives from the additive latency and the CAS write latency mode settings. While a WRITE burst is on the bus, the write value replaces the nominal value. When the burst ends, the nominal value comes back.

The block also checks the minimum high time of the termination-enable pin. Once the pin is registered high, it has to stay high for four clocks. Each WRITE accepted while the pin is high starts that four-clock count again. If the pin is registered low too early, a one-cycle error pulse is raised, and the low is still honoured.

All pins are plain control and status signals. There is no streamed data, so no valid/ready handshake and no back-pressure. The mode inputs are treated as static between resets. WRITE commands are assumed to be at least four clocks apart.

Top module: `ddr_dyn_odt_ctrl`

## Requirements
- R1: When `rtt_nom_en` is 1, `odt_in` registered high at edge n makes `rtt_sel` read 2'b01 (nominal) in the cycle after edge n+WL-2, where WL = `al_cfg` + `cwl_cfg`.
- R2: `odt_in` registered low at edge n makes `rtt_sel` read 2'b00 (off) in the cycle after edge n+WL-2, unless a write window covers that cycle.
- R3: A WRITE is accepted only when `wr_cmd` and `odt_in` are both high at the same edge n. With `rtt_wr_en` at 1 and `wr_bc4` at 0, an accepted WRITE makes `rtt_sel` read 2'b10 (write) after edges n+WL through n+WL+3. After that, the termination returns to what `odt_in` selects. A WRITE with `odt_in` low changes nothing.
- R4: An accepted WRITE with `wr_bc4` at 1 holds 2'b10 only after edges n+WL and n+WL+1.
- R5: With `rtt_wr_en` at 0, an accepted WRITE leaves `rtt_sel` at the value that `odt_in` alone would give.
- R6: With `rtt_nom_en` at 0, the cycles that would read nominal read 2'b00 instead.
- R7: `odth4_err` pulses for exactly the one cycle after an edge that registers `odt_in` low when fewer than four edges have passed since the last start event. A start event is `odt_in` registered high after a low, or an accepted WRITE. A low registered exactly four edges after the start event is legal.
- R8: WL is the sum of `al_cfg` (0 to 15) and `cwl_cfg` (5 to 15). Every latency above follows that sum.
- R9: `rst` is synchronous and active high. It forces `rtt_sel` to 2'b00 and `odth4_err` to 0, and it clears all latency history, so values seen during reset never reach the output.
- R10: The write value has priority over a turn-off that falls inside a write window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| odt_in | input | 1 | Registered termination-enable pin |
| wr_cmd | input | 1 | Decoded WRITE command strobe |
| wr_bc4 | input | 1 | WRITE is a chopped four-beat burst |
| al_cfg | input | 4 | Additive latency setting |
| cwl_cfg | input | 4 | CAS write latency setting |
| rtt_nom_en | input | 1 | Nominal termination value enabled |
| rtt_wr_en | input | 1 | Write termination value enabled |
| rtt_sel | output | 2 | Termination select: 00 off, 01 nominal, 10 write |
| odth4_err | output | 1 | One-cycle minimum-high-time violation pulse |

## Verification
The bench targets several timing corners. A low registered exactly four edges after a rise must not flag, and a low one or three edges after a rise must flag. A design counting from the wrong edge would flag the legal case or miss the short one. A low four edges after a WRITE must pass even when the rise was earlier. A design that ignores WRITE as a start event would stay silent on a low three edges after a WRITE.

The bench lets a turn-off land inside a BL8 write window, where an inverted priority would drop the termination early. It compares chopped and full bursts, where an off-by-one window length shows as one cycle too many or too few of the write value.

It drives WRITEs with the pin low, and it asserts the pin and WRITE during reset. A design that accepts such WRITEs, or lets reset-time history leak into the output, would show termination where none is expected. Random configurations then vary both latencies and both enables.

// File: rtl/ddr_term_pkg.sv
package ddr_term_pkg;
  typedef enum logic [1:0] {
    TERM_OFF = 2'b00,
    TERM_NOM = 2'b01,
    TERM_WR  = 2'b10
  } term_sel_e;
endpackage

// File: rtl/ddr_term_latency.sv
module ddr_term_latency #(
  parameter int AL_W  = 4,
  parameter int CWL_W = 4,
  parameter int LAT_W = 5
) (
  input  logic [AL_W-1:0]  al_cfg,
  input  logic [CWL_W-1:0] cwl_cfg,
  output logic [LAT_W-1:0] wr_lat,
  output logic [LAT_W-1:0] odt_lat
);
  localparam logic [LAT_W-1:0] ODT_SHORTEN = LAT_W'(2);

  always_comb begin
    wr_lat  = LAT_W'(al_cfg) + LAT_W'(cwl_cfg);
    odt_lat = (wr_lat >= ODT_SHORTEN) ? (wr_lat - ODT_SHORTEN) : '0;
  end
endmodule

// File: rtl/ddr_term_delay.sv
module ddr_term_delay #(
  parameter int DEPTH = 31,
  parameter int W     = 1,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [W-1:0]     d,
  input  logic [IDX_W-1:0] tap,
  output logic [W-1:0]     q
);
  logic [W-1:0] stage [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) stage[i] <= '0;
    end else begin
      stage[0] <= d;
      for (int i = 1; i < DEPTH; i++) stage[i] <= stage[i-1];
    end
  end

  always_comb begin
    if (int'(tap) < DEPTH) q = stage[tap];
    else                   q = '0;
  end
endmodule

// File: rtl/ddr_term_write_window.sv
module ddr_term_write_window #(
  parameter int BL8_LEN = 4,
  parameter int BC4_LEN = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic chop,
  output logic active
);
  localparam int CNT_W = $clog2(BL8_LEN);

  logic [CNT_W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q <= '0;
    end else if (start) begin
      left_q <= chop ? CNT_W'(BC4_LEN - 1) : CNT_W'(BL8_LEN - 1);
    end else if (left_q != '0) begin
      left_q <= left_q - 1'b1;
    end
  end

  assign active = start || (left_q != '0);

  // R3: a burst that begins stays in the write value on the following cycle
  p_burst_holds_r3: assert property (@(posedge clk) disable iff (rst)
    start |=> active);
endmodule

// File: rtl/ddr_term_odth4.sv
module ddr_term_odth4 #(
  parameter int HOLD = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic odt_in,
  input  logic wr_acc,
  output logic err
);
  localparam int CNT_W = $clog2(HOLD);

  logic             odt_q;
  logic [CNT_W-1:0] remain_q;
  logic             err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      odt_q    <= 1'b0;
      remain_q <= '0;
      err_q    <= 1'b0;
    end else begin
      odt_q <= odt_in;
      err_q <= !odt_in && (remain_q != '0);
      if (!odt_in)
        remain_q <= '0;
      else if (!odt_q || wr_acc)
        remain_q <= CNT_W'(HOLD - 1);
      else if (remain_q != '0)
        remain_q <= remain_q - 1'b1;
    end
  end

  assign err = err_q;

  // R7: the violation flag is a single-cycle pulse
  p_err_single_r7: assert property (@(posedge clk) disable iff (rst)
    err_q |=> !err_q);
  // R7: a violation is only reported on a high-to-low registration
  p_err_on_fall_r7: assert property (@(posedge clk) disable iff (rst)
    err_q |-> (!odt_q && $past(odt_q)));
endmodule

// File: rtl/ddr_dyn_odt_ctrl.sv
module ddr_dyn_odt_ctrl #(
  parameter int AL_W    = 4,
  parameter int CWL_W   = 4,
  parameter int BL8_LEN = 4,
  parameter int BC4_LEN = 2,
  parameter int HOLD    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             odt_in,
  input  logic             wr_cmd,
  input  logic             wr_bc4,
  input  logic [AL_W-1:0]  al_cfg,
  input  logic [CWL_W-1:0] cwl_cfg,
  input  logic             rtt_nom_en,
  input  logic             rtt_wr_en,
  output logic [1:0]       rtt_sel,
  output logic             odth4_err
);
  import ddr_term_pkg::*;

  localparam int LAT_W = ((AL_W > CWL_W) ? AL_W : CWL_W) + 1;
  localparam int DEPTH = (1 << AL_W) + (1 << CWL_W) - 1;

  logic [LAT_W-1:0] wr_lat, odt_lat;
  logic             wr_acc;
  logic             odt_tap;
  logic [1:0]       wr_tap;
  logic             win_active;
  term_sel_e        sel;

  assign wr_acc = wr_cmd && odt_in;

  ddr_term_latency #(.AL_W(AL_W), .CWL_W(CWL_W), .LAT_W(LAT_W)) u_lat (
    .al_cfg (al_cfg),
    .cwl_cfg(cwl_cfg),
    .wr_lat (wr_lat),
    .odt_lat(odt_lat)
  );

  ddr_term_delay #(.DEPTH(DEPTH), .W(1), .IDX_W(LAT_W)) u_odt_hist (
    .clk(clk), .rst(rst), .d(odt_in), .tap(odt_lat), .q(odt_tap)
  );

  ddr_term_delay #(.DEPTH(DEPTH), .W(2), .IDX_W(LAT_W)) u_wr_hist (
    .clk(clk), .rst(rst), .d({wr_acc && wr_bc4, wr_acc}), .tap(wr_lat), .q(wr_tap)
  );

  ddr_term_write_window #(.BL8_LEN(BL8_LEN), .BC4_LEN(BC4_LEN)) u_win (
    .clk(clk), .rst(rst), .start(wr_tap[0]), .chop(wr_tap[1]), .active(win_active)
  );

  ddr_term_odth4 #(.HOLD(HOLD)) u_hold (
    .clk(clk), .rst(rst), .odt_in(odt_in), .wr_acc(wr_acc), .err(odth4_err)
  );

  always_comb begin
    if (win_active && rtt_wr_en)   sel = TERM_WR;
    else if (odt_tap && rtt_nom_en) sel = TERM_NOM;
    else                           sel = TERM_OFF;
  end

  assign rtt_sel = sel;

  // R9: reset leaves the termination off and no error pending
  p_reset_off_r9: assert property (@(posedge clk)
    rst |=> (rtt_sel == 2'b00 && !odth4_err));
  // R5: the write value only appears when it is enabled
  p_wr_needs_en_r5: assert property (@(posedge clk) disable iff (rst)
    (rtt_sel == 2'b10) |-> rtt_wr_en);
  // R6: the nominal value only appears when it is enabled
  p_nom_needs_en_r6: assert property (@(posedge clk) disable iff (rst)
    (rtt_sel == 2'b01) |-> rtt_nom_en);
endmodule

// File: tb/sim_ddr_dyn_odt_ctrl.sv
module sim_ddr_dyn_odt_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int MAXC = 4096;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic odt_in = 1'b0, wr_cmd = 1'b0, wr_bc4 = 1'b0;
  logic [3:0] al_cfg = 4'd0, cwl_cfg = 4'd5;
  logic rtt_nom_en = 1'b1, rtt_wr_en = 1'b1;
  logic [1:0] rtt_sel;
  logic odth4_err;

  int vectors = 0, miscompares = 0;
  int n = 0, seg_start = 0, last_wr = -4;
  int cur_al = 0, cur_cwl = 5;
  bit cur_nom = 1, cur_wr = 1;
  bit odt_a [MAXC];
  bit wr_a  [MAXC];
  bit bc4_a [MAXC];

  always #(CLK_PERIOD/2) clk = ~clk;

  ddr_dyn_odt_ctrl u0 (
    .clk(clk), .rst(rst), .odt_in(odt_in), .wr_cmd(wr_cmd), .wr_bc4(wr_bc4),
    .al_cfg(al_cfg), .cwl_cfg(cwl_cfg), .rtt_nom_en(rtt_nom_en),
    .rtt_wr_en(rtt_wr_en), .rtt_sel(rtt_sel), .odth4_err(odth4_err)
  );

  function automatic bit f_odt(int c);
    return (c >= seg_start) ? odt_a[c] : 1'b0;
  endfunction
  function automatic bit f_acc(int c);
    return (c >= seg_start) ? (odt_a[c] && wr_a[c]) : 1'b0;
  endfunction
  function automatic bit f_start(int c);
    return f_odt(c) && (!f_odt(c-1) || f_acc(c));
  endfunction
  function automatic bit exp_err(int c);
    return !f_odt(c) && f_odt(c-1) &&
           (f_start(c-1) || f_start(c-2) || f_start(c-3));
  endfunction

  task automatic check(string tag, int act, int exp, string what);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s cycle=%0d actual=%0d expected=%0d", tag, what, n, act, exp);
    end
  endtask

  task automatic check_cycle();
    int wl = cur_al + cur_cwl;
    int lat = (wl >= 2) ? wl - 2 : 0;
    bit win = 0, chop = 0, nomsrc;
    int exp;
    string tag;
    for (int k = 0; k < 4; k++) begin
      int c = n - wl - k;
      if (f_acc(c) && (k < (bc4_a[c] ? 2 : 4))) begin
        win = 1; chop = bc4_a[c];
      end
    end
    nomsrc = f_odt(n - lat);
    if (win && cur_wr) exp = 2;
    else if (nomsrc && cur_nom) exp = 1;
    else exp = 0;
    if (win && !cur_wr) tag = "R5";
    else if (nomsrc && !cur_nom && !win) tag = "R6";
    else if (exp == 2 && !nomsrc) tag = "R10";
    else if (exp == 2) tag = chop ? "R4" : "R3";
    else if (exp == 1) tag = (cur_al != 0) ? "R8" : "R1";
    else tag = "R2";
    check(tag, int'(rtt_sel), exp, "rtt_sel");
    check("R7", int'(odth4_err), int'(exp_err(n)), "odth4_err");
  endtask

  task automatic step(bit o, bit w, bit b);
    odt_in = o; wr_cmd = w; wr_bc4 = b;
    odt_a[n] = o; wr_a[n] = w; bc4_a[n] = b;
    if (w) last_wr = n;
    @(posedge clk);
    @(negedge clk);
    check_cycle();
    n++;
  endtask

  // Reset with pin and WRITE held high: R9 requires none of it to leak out.
  task automatic do_reset(int a, int c, bit ne, bit we);
    cur_al = a; cur_cwl = c; cur_nom = ne; cur_wr = we;
    al_cfg = 4'(a); cwl_cfg = 4'(c); rtt_nom_en = ne; rtt_wr_en = we;
    rst = 1'b1; odt_in = 1'b1; wr_cmd = 1'b1; wr_bc4 = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9", int'(rtt_sel), 0, "rtt_sel in reset");
    check("R9", int'(odth4_err), 0, "odth4_err in reset");
    rst = 1'b0;
    seg_start = n;
    last_wr = n - 4;
  endtask

  task automatic hold(bit o, int cycles);
    for (int i = 0; i < cycles; i++) step(o, 1'b0, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    miscompares++;
    $display("FAIL watchdog expired at cycle %0d actual=hung expected=done", n);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    bit o;
    void'($urandom(32'h0D7_5EED));
    @(negedge clk);

    // Directed corners, AL 0, CWL 5
    do_reset(0, 5, 1, 1);
    hold(1, 4); hold(0, 4);                 // R7: low exactly four after rise, legal
    hold(1, 1); hold(0, 4);                 // R7: low one after rise, flagged
    hold(1, 3); hold(0, 4);                 // R7: low three after rise, flagged
    hold(1, 4); step(1, 1, 0); hold(1, 3);  // R3: BL8 write, then
    hold(0, 6);                             // R10: low four after write, off inside window
    hold(1, 2); step(1, 1, 0); hold(1, 2);  // R7: low three after write
    hold(0, 6);
    step(0, 1, 1); hold(0, 6);              // R3: write with pin low ignored
    hold(1, 3); step(1, 1, 1); hold(1, 6);  // R4: chopped burst
    hold(0, 8);

    // R5: write value disabled
    do_reset(0, 5, 1, 0);
    hold(1, 4); step(1, 1, 0); hold(1, 8); hold(0, 8);
    // R6: nominal value disabled
    do_reset(0, 5, 0, 1);
    hold(1, 4); step(1, 1, 0); hold(1, 8); hold(0, 8);
    // R8: nonzero additive latency
    do_reset(3, 8, 1, 1);
    hold(1, 5); step(1, 1, 0); hold(1, 5); step(1, 1, 1); hold(1, 5); hold(0, 20);

    // Random configurations and traffic
    for (int seg = 0; seg < 8; seg++) begin
      do_reset(int'($urandom % 16), 5 + int'($urandom % 11),
               bit'($urandom % 4 != 0), bit'($urandom % 4 != 0));
      o = 0;
      for (int i = 0; i < 300; i++) begin
        bit w, b;
        if ($urandom % 5 == 0) o = !o;
        w = ((n - last_wr) >= 4) && ($urandom % 4 == 0);
        b = bit'($urandom % 2);
        step(o, w, b);
      end
      hold(0, 40);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule